// File: doc/BRIEF.md
# Message Buffer Completion Flag and Interrupt Unit

This block records, for each of 64 message buffers, whether that buffer has finished a transfer. The buffer manager sends one pulse on a buffer's completion line when the buffer completes a successful transmit or receive. The direction of the transfer is not recorded: each buffer has a single flag that covers both cases. The flag stays set until software clears it. To clear a flag, software writes a 1 to the flag's bit through a small register write port. Writing a 0 to a bit leaves that bit unchanged.

The flags sit in two 32-bit words. The low word holds buffers 0 to 31 and the high word holds buffers 32 to 63, with bit n belonging to buffer n modulo 32. Each flag has an enable bit in a matching mask word. A buffer raises an interrupt only when both its flag and its enable bit are set. Buffers 0 to 15 each drive their own interrupt line. Buffers 16 to 31 are ORed into one shared line, and buffers 32 to 63 are ORed into a second shared line. When a shared line is raised, software reads the flag words to find which buffer caused it. The flag words and mask words are always visible on output ports. All interrupt lines come from registers.

Top module: `mbflag_unit`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears all flags, all mask bits and all interrupt outputs to zero.
- R2: A high on done_i[n] at a clock edge sets the flag for buffer n at that edge. Buffers 0-31 appear on flag_lo_o bit n and buffers 32-63 appear on flag_hi_o bit n-32. There is one flag per buffer, whatever the transfer direction.
- R3: With wr_en_i high, wr_sel_i 0 selects the low flag word and wr_sel_i 1 selects the high flag word. Each 1 in wr_data_i clears the matching flag at that edge. Each 0 leaves the matching flag unchanged. A flag-word write never touches the other word.
- R4: If a completion pulse and a write-1 clear reach the same flag at the same edge, the flag ends set.
- R5: With wr_en_i high, wr_sel_i 2 loads wr_data_i into mask_lo_o and wr_sel_i 3 loads it into mask_hi_o, at that edge. Flags are unchanged by mask writes.
- R6: irq_buf_o[n] (n = 0..15) equals flag n AND mask n as they stood one cycle earlier.
- R7: irq_grp_mid_o equals the OR of flag AND mask over buffers 16-31 as they stood one cycle earlier.
- R8: irq_grp_hi_o equals the OR of flag AND mask over buffers 32-63 as they stood one cycle earlier.
- R9: A set flag stays set when its completion pulse ends and no write-1 clear reaches it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| done_i | input | 64 | Per-buffer completion pulse, bit n for buffer n |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 flag low, 1 flag high, 2 mask low, 3 mask high |
| wr_data_i | input | 32 | Write data |
| flag_lo_o | output | 32 | Flags of buffers 0-31 |
| flag_hi_o | output | 32 | Flags of buffers 32-63 |
| mask_lo_o | output | 32 | Enable bits of buffers 0-31 |
| mask_hi_o | output | 32 | Enable bits of buffers 32-63 |
| irq_buf_o | output | 16 | Dedicated interrupts of buffers 0-15 |
| irq_grp_mid_o | output | 1 | Combined interrupt of buffers 16-31 |
| irq_grp_hi_o | output | 1 | Combined interrupt of buffers 32-63 |

## Verification
The flag and mask words drive the output ports directly. A flag that is lost, stuck, or cleared by the wrong write therefore shows on flag_lo_o or flag_hi_o in the same cycle the faulty update takes effect. An error in the interrupt path, such as the wrong group boundary, a missing mask gate or the wrong latency, shows on the interrupt lines exactly one cycle after the flag or mask change that should have caused it. The bench therefore checks the flag words one edge after each stimulus and the interrupt lines one edge after that.

// File: rtl/mbflag_pkg.sv
package mbflag_pkg;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 2;
    localparam int N_BANK = 2;

    typedef logic [REG_W-1:0] word_t;

    // Register select codes seen on the write port
    typedef enum logic [ADDR_W-1:0] {
        SEL_FLAG_LO = 2'd0,
        SEL_FLAG_HI = 2'd1,
        SEL_MASK_LO = 2'd2,
        SEL_MASK_HI = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/mbflag_bank.sv
// One 32-buffer bank: completion flags with write-1-to-clear plus enable bits.
module mbflag_bank
    import mbflag_pkg::*;
#(
    parameter int              W        = REG_W,
    parameter logic [ADDR_W-1:0] FLAG_SEL = 2'd0,
    parameter logic [ADDR_W-1:0] MASK_SEL = 2'd2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      set_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_sel_i,
    input  logic [W-1:0]      wr_data_i,
    output logic [W-1:0]      flag_o,
    output logic [W-1:0]      mask_o
);
    typedef struct packed {
        logic [W-1:0] flag;
        logic [W-1:0] mask;
    } bank_t;

    bank_t st_d, st_q;
    logic [W-1:0] clr_vec;

    always_comb begin
        st_d    = st_q;
        clr_vec = '0;
        if (wr_en_i && (wr_sel_i == FLAG_SEL)) begin
            clr_vec = wr_data_i;
        end
        // Clear first, then set: a simultaneous completion is kept
        st_d.flag = (st_q.flag & ~clr_vec) | set_i;
        if (wr_en_i && (wr_sel_i == MASK_SEL)) begin
            st_d.mask = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;
    assign mask_o = st_q.mask;
endmodule

// File: rtl/mbflag_irq.sv
// Gates flags with enables and forms dedicated and grouped interrupt lines.
module mbflag_irq #(
    parameter int N_BUF     = 64,
    parameter int N_DED     = 16,
    parameter int GRP_SPLIT = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_BUF-1:0] flag_i,
    input  logic [N_BUF-1:0] mask_i,
    output logic [N_DED-1:0] ded_o,
    output logic             grp_mid_o,
    output logic             grp_hi_o
);
    typedef struct packed {
        logic [N_DED-1:0] ded;
        logic             mid;
        logic             hi;
    } irq_t;

    irq_t irq_d, irq_q;
    logic [N_BUF-1:0] src;

    always_comb begin
        src       = flag_i & mask_i;
        irq_d.ded = src[N_DED-1:0];
        irq_d.mid = |src[GRP_SPLIT-1:N_DED];
        irq_d.hi  = |src[N_BUF-1:GRP_SPLIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= '0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign ded_o     = irq_q.ded;
    assign grp_mid_o = irq_q.mid;
    assign grp_hi_o  = irq_q.hi;
endmodule

// File: rtl/mbflag_unit.sv
module mbflag_unit
    import mbflag_pkg::*;
#(
    parameter int N_DED = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2*REG_W-1:0]      done_i,
    input  logic                    wr_en_i,
    input  logic [ADDR_W-1:0]       wr_sel_i,
    input  logic [REG_W-1:0]        wr_data_i,
    output logic [REG_W-1:0]        flag_lo_o,
    output logic [REG_W-1:0]        flag_hi_o,
    output logic [REG_W-1:0]        mask_lo_o,
    output logic [REG_W-1:0]        mask_hi_o,
    output logic [N_DED-1:0]        irq_buf_o,
    output logic                    irq_grp_mid_o,
    output logic                    irq_grp_hi_o
);
    localparam int NUM_BUF = N_BANK * REG_W;

    logic [NUM_BUF-1:0] flag_all;
    logic [NUM_BUF-1:0] mask_all;

    for (genvar b = 0; b < N_BANK; b++) begin : g_bank
        mbflag_bank #(
            .W        (REG_W),
            .FLAG_SEL (ADDR_W'(b)),
            .MASK_SEL (ADDR_W'(N_BANK + b))
        ) bank_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_i     (done_i[b*REG_W +: REG_W]),
            .wr_en_i   (wr_en_i),
            .wr_sel_i  (wr_sel_i),
            .wr_data_i (wr_data_i),
            .flag_o    (flag_all[b*REG_W +: REG_W]),
            .mask_o    (mask_all[b*REG_W +: REG_W])
        );
    end

    mbflag_irq #(
        .N_BUF     (NUM_BUF),
        .N_DED     (N_DED),
        .GRP_SPLIT (REG_W)
    ) irq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flag_i    (flag_all),
        .mask_i    (mask_all),
        .ded_o     (irq_buf_o),
        .grp_mid_o (irq_grp_mid_o),
        .grp_hi_o  (irq_grp_hi_o)
    );

    assign flag_lo_o = flag_all[REG_W-1:0];
    assign flag_hi_o = flag_all[NUM_BUF-1:REG_W];
    assign mask_lo_o = mask_all[REG_W-1:0];
    assign mask_hi_o = mask_all[NUM_BUF-1:REG_W];
endmodule

// File: rtl/mbflag_unit_chk.sv
module mbflag_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [63:0] done_i,
    input logic        wr_en_i,
    input logic [1:0]  wr_sel_i,
    input logic [31:0] wr_data_i,
    input logic [31:0] flag_lo_o,
    input logic [31:0] flag_hi_o,
    input logic [31:0] mask_lo_o,
    input logic [31:0] mask_hi_o,
    input logic [15:0] irq_buf_o,
    input logic        irq_grp_mid_o,
    input logic        irq_grp_hi_o
);
    logic [31:0] clr_lo, clr_hi;
    assign clr_lo = (wr_en_i && wr_sel_i == 2'd0) ? wr_data_i : 32'h0;
    assign clr_hi = (wr_en_i && wr_sel_i == 2'd1) ? wr_data_i : 32'h0;

    p_set_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_lo_o & $past(done_i[31:0])) == $past(done_i[31:0])));
    p_set_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_hi_o & $past(done_i[63:32])) == $past(done_i[63:32])));
    p_clear_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(flag_lo_o) & ~flag_lo_o) & ~$past(clr_lo)) == 32'h0));
    p_clear_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(flag_hi_o) & ~flag_hi_o) & ~$past(clr_hi)) == 32'h0));
    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_lo & done_i[31:0]) != 32'h0)
        |=> ((flag_lo_o & $past(clr_lo & done_i[31:0])) == $past(clr_lo & done_i[31:0])));
    p_mask_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == 2'd2) |=> (mask_lo_o == $past(wr_data_i)));
    p_mask_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == 2'd3) |=> (mask_hi_o == $past(wr_data_i)));
    p_ded_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_buf_o == $past(flag_lo_o[15:0] & mask_lo_o[15:0])));
    p_mid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_grp_mid_o == $past(|(flag_lo_o[31:16] & mask_lo_o[31:16]))));
    p_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_grp_hi_o == $past(|(flag_hi_o & mask_hi_o))));
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> ((($past(flag_lo_o) & ~flag_lo_o) == 32'h0) &&
                      (($past(flag_hi_o) & ~flag_hi_o) == 32'h0)));
endmodule

bind mbflag_unit mbflag_unit_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .done_i        (done_i),
    .wr_en_i       (wr_en_i),
    .wr_sel_i      (wr_sel_i),
    .wr_data_i     (wr_data_i),
    .flag_lo_o     (flag_lo_o),
    .flag_hi_o     (flag_hi_o),
    .mask_lo_o     (mask_lo_o),
    .mask_hi_o     (mask_hi_o),
    .irq_buf_o     (irq_buf_o),
    .irq_grp_mid_o (irq_grp_mid_o),
    .irq_grp_hi_o  (irq_grp_hi_o)
);

// File: tb/mbflag_unit_tb.sv
`timescale 1ns/1ps
module mbflag_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] done_i = '0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_sel_i = '0;
    logic [31:0] wr_data_i = '0;
    logic [31:0] flag_lo_o, flag_hi_o, mask_lo_o, mask_hi_o;
    logic [15:0] irq_buf_o;
    logic        irq_grp_mid_o, irq_grp_hi_o;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    mbflag_unit dut_i (
        .clk(clk), .rst_n(rst_n), .done_i(done_i), .wr_en_i(wr_en_i),
        .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .flag_lo_o(flag_lo_o),
        .flag_hi_o(flag_hi_o), .mask_lo_o(mask_lo_o), .mask_hi_o(mask_hi_o),
        .irq_buf_o(irq_buf_o), .irq_grp_mid_o(irq_grp_mid_o),
        .irq_grp_hi_o(irq_grp_hi_o)
    );

    typedef struct packed {
        logic [63:0] done;
        logic        wr;
        logic [1:0]  sel;
        logic [31:0] data;
        logic [31:0] exp_lo;
        logic [31:0] exp_hi;
    } vec_t;

    // Applied in order from reset; expected flag words after each step
    localparam vec_t VECS [8] = '{
        '{64'h0000_0000_0000_0001, 1'b0, 2'd0, 32'h0,         32'h0000_0001, 32'h0000_0000}, // R2 low
        '{64'h8000_0000_0000_0000, 1'b0, 2'd0, 32'h0,         32'h0000_0001, 32'h8000_0000}, // R2 high
        '{64'h0,                   1'b1, 2'd0, 32'h0,         32'h0000_0001, 32'h8000_0000}, // R3 zeros
        '{64'h0000_0100_0000_0000, 1'b1, 2'd1, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0100}, // R4 high
        '{64'h0000_0000_0001_0000, 1'b1, 2'd0, 32'h0000_0001, 32'h0001_0000, 32'h0000_0100}, // R3 clear
        '{64'h0000_0000_0000_0004, 1'b1, 2'd0, 32'h0000_0004, 32'h0001_0004, 32'h0000_0100}, // R4 low
        '{64'h0,                   1'b1, 2'd1, 32'h0000_0100, 32'h0001_0004, 32'h0000_0000}, // R3 high
        '{64'h0,                   1'b1, 2'd2, 32'h0000_FFFF, 32'h0001_0004, 32'h0000_0000}  // R5 no flag change
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive on the falling edge, clock once, release, sample at the next falling edge
    task automatic step(input logic [63:0] d, input logic w, input logic [1:0] s, input logic [31:0] x);
        done_i = d; wr_en_i = w; wr_sel_i = s; wr_data_i = x;
        @(posedge clk);
        @(negedge clk);
        done_i = '0; wr_en_i = 1'b0; wr_sel_i = '0; wr_data_i = '0;
    endtask

    task automatic idle();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 flags", {flag_hi_o, flag_lo_o}, 64'h0);
        chk("R1 masks", {mask_hi_o, mask_lo_o}, 64'h0);
        chk("R1 irq", {46'h0, irq_buf_o, irq_grp_mid_o, irq_grp_hi_o}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 8; i++) begin
            step(VECS[i].done, VECS[i].wr, VECS[i].sel, VECS[i].data);
            chk($sformatf("R2/R3/R4 vector %0d", i), {flag_hi_o, flag_lo_o},
                {VECS[i].exp_hi, VECS[i].exp_lo});
        end

        chk("R5 mask low", {32'h0, mask_lo_o}, 64'h0000_FFFF);
        // R6: flags 2 and 16 set, mask low half only
        idle();
        chk("R6 dedicated", {48'h0, irq_buf_o}, 64'h4);
        chk("R7 group mid masked", {63'h0, irq_grp_mid_o}, 64'h0);
        step(64'h0, 1'b1, 2'd2, 32'hFFFF_FFFF);
        chk("R7 latency", {63'h0, irq_grp_mid_o}, 64'h0);
        idle();
        chk("R7 group mid", {63'h0, irq_grp_mid_o}, 64'h1);

        // R8: buffer 32 with its enable written in the same cycle
        step(64'h0000_0001_0000_0000, 1'b1, 2'd3, 32'h0000_0001);
        chk("R8 flag/mask", {flag_hi_o, mask_hi_o}, {32'h1, 32'h1});
        chk("R8 latency", {63'h0, irq_grp_hi_o}, 64'h0);
        idle();
        chk("R8 group hi", {63'h0, irq_grp_hi_o}, 64'h1);
        idle();
        chk("R9 held", {flag_hi_o, flag_lo_o}, {32'h1, 32'h0001_0004});
        step(64'h0, 1'b1, 2'd1, 32'h0000_0001);
        chk("R3 clear hi", {32'h0, flag_hi_o}, 64'h0);
        chk("R3 low untouched", {32'h0, flag_lo_o}, 64'h0001_0004);
        idle();
        chk("R8 drop", {63'h0, irq_grp_hi_o}, 64'h0);

        // R2: same flag for a buffer in the dedicated range, held after pulse
        step(64'h0000_0000_0000_8000, 1'b0, 2'd0, 32'h0);
        idle();
        chk("R6 buffer 15", {48'h0, irq_buf_o}, 64'h8004);

        rst_n = 1'b0;
        #1;
        chk("R1 async flags", {flag_hi_o, flag_lo_o}, 64'h0);
        chk("R1 async masks", {mask_hi_o, mask_lo_o}, 64'h0);
        chk("R1 async irq", {46'h0, irq_buf_o, irq_grp_mid_o, irq_grp_hi_o}, 64'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule